// File: doc/BRIEF.md
# Four-Byte Register Reader Target for SMBus

This block is a target on a two-wire SMBus/I2C segment. It lets a host read a small set of read-only 32-bit status words. The words are supplied by neighbouring logic on parallel input ports: power and temperature readings in floating-point form, PCI identity words and a name word. The block runs entirely on the system clock. Both bus lines pass through synchronizers, and the block recovers clock edges and START/STOP conditions from the synchronized levels.

A read has two phases. In the first, the host addresses the target for writing and sends one pointer byte. In the second, the host issues a repeated START, addresses the target for reading, and clocks out four data bytes. The lowest byte of the word comes first. The host acknowledges the first three bytes, gives no acknowledge on the fourth, and then ends with STOP.

The target only ever pulls SDA low or releases it; an external pull-up supplies the high level. There is no data stream at the block's edge. The register inputs are plain levels with no valid/ready handshake. They are sampled once per read, so no back-pressure applies.

Top module: `smbrd_target`

## Requirements
- R1: The target acknowledges (pulls SDA low during the ninth clock) only the address bytes 0x8E (write) and 0x8F (read): 7-bit address 0x47 with the read flag in bit 0. For any other address byte it stays silent, and it also stays silent for every following byte until the next START.
- R2: After an acknowledged write address, the next byte is taken as the register pointer and is always acknowledged, whatever its value.
- R3: After a repeated START and an acknowledged read address, the selected word goes out as four bytes in the order bits [7:0], [15:8], [23:16], [31:24]. Each byte is sent most significant bit first.
- R4: Pointer 0x01 selects the power word, 0x02 the board temperature word and 0x03 the die temperature word.
- R5: Pointer 0xA0 returns vendor ID in [15:0] and device ID in [31:16]. Pointer 0xA1 returns sub-vendor ID in [15:0] and subsystem ID in [31:16]. Pointer 0xF0 returns the name word.
- R6: Any pointer value not listed in R4/R5 reads as 0x00000000.
- R7: The word is captured when the read address is acknowledged. Input changes during the data bytes do not alter the bytes sent.
- R8: When the host does not acknowledge a data byte, or after the fourth byte, the target releases SDA and further clocks read 0xFF.
- R9: A STOP at any point, or a START in the middle of a byte, returns the target to its idle or address state with SDA released. A complete transaction that follows works normally.
- R10: The target changes its SDA drive only while SCL is low.
- R11: After reset, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| power_word_i | input | 32 | Total power value (pointer 0x01) |
| board_temp_word_i | input | 32 | Board temperature value (pointer 0x02) |
| die_temp_word_i | input | 32 | Die temperature value (pointer 0x03) |
| vendor_id_i | input | 16 | Vendor ID |
| device_id_i | input | 16 | Device ID |
| subvendor_id_i | input | 16 | Sub-vendor ID |
| subsystem_id_i | input | 16 | Subsystem ID |
| name_word_i | input | 32 | Device name word (pointer 0xF0) |

## Verification
A wrong bit count or a wrong state shows up at the ports within one bit time. It appears as an acknowledge in the wrong clock, or as a data bit shifted by one position. A stale or wrong byte-lane selection shows as a wrong byte in the four-byte word that a full read returns. A failed release after NACK, STOP or a foreign address appears as a low bit where the host expects the line to float high. Every check is therefore made at the bus pins, on every byte of every transaction.

// File: rtl/smbrd_pkg.sv
package smbrd_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_BYTES = WORD_W / BYTE_W;

  localparam logic [7:0] PTR_POWER  = 8'h01;
  localparam logic [7:0] PTR_BTEMP  = 8'h02;
  localparam logic [7:0] PTR_DTEMP  = 8'h03;
  localparam logic [7:0] PTR_IDS    = 8'hA0;
  localparam logic [7:0] PTR_SUBIDS = 8'hA1;
  localparam logic [7:0] PTR_NAME   = 8'hF0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_ADDR,
    ST_ADDR_ACK,
    ST_RX_PTR,
    ST_PTR_ACK,
    ST_TX,
    ST_HOST_ACK,
    ST_HOLD
  } tgt_state_t;
endpackage

// File: rtl/smbrd_sync.sv
module smbrd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '1;
      else        stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/smbrd_cond_detect.sv
module smbrd_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = !scl_q && scl_s;
  assign scl_fall  = scl_q && !scl_s;
  assign start_det = scl_q && scl_s && sda_q && !sda_s;
  assign stop_det  = scl_q && scl_s && !sda_q && sda_s;
endmodule

// File: rtl/smbrd_regbank.sv
module smbrd_regbank
  import smbrd_pkg::*;
(
  input  logic [7:0]        ptr,
  input  logic [WORD_W-1:0] power_word,
  input  logic [WORD_W-1:0] btemp_word,
  input  logic [WORD_W-1:0] dtemp_word,
  input  logic [15:0]       vendor_id,
  input  logic [15:0]       device_id,
  input  logic [15:0]       subvendor_id,
  input  logic [15:0]       subsystem_id,
  input  logic [WORD_W-1:0] name_word,
  output logic [WORD_W-1:0] sel_word
);
  always_comb begin
    unique case (ptr)
      PTR_POWER:  sel_word = power_word;
      PTR_BTEMP:  sel_word = btemp_word;
      PTR_DTEMP:  sel_word = dtemp_word;
      PTR_IDS:    sel_word = {device_id, vendor_id};
      PTR_SUBIDS: sel_word = {subsystem_id, subvendor_id};
      PTR_NAME:   sel_word = name_word;
      default:    sel_word = '0;
    endcase
  end
endmodule

// File: rtl/smbrd_target.sv
module smbrd_target
  import smbrd_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h47,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  input  logic [31:0] power_word_i,
  input  logic [31:0] board_temp_word_i,
  input  logic [31:0] die_temp_word_i,
  input  logic [15:0] vendor_id_i,
  input  logic [15:0] device_id_i,
  input  logic [15:0] subvendor_id_i,
  input  logic [15:0] subsystem_id_i,
  input  logic [31:0] name_word_i
);
  localparam logic [3:0] BIT_LAST  = 4'(BYTE_W);
  localparam logic [2:0] BYTE_LAST = 3'(WORD_BYTES);

  logic [1:0] line_s;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  smbrd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_i, sda_i}),
    .dout (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  smbrd_cond_detect u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  tgt_state_t        state;
  logic [3:0]        bit_cnt;
  logic [2:0]        byte_cnt;
  logic [7:0]        rx_sr;
  logic [7:0]        ptr_q;
  logic              rw_q;
  logic              host_nack;
  logic [WORD_W-1:0] snap_q;
  logic [7:0]        tx_sr;
  logic              drive_low;
  logic [WORD_W-1:0] sel_word;

  smbrd_regbank u_bank (
    .ptr         (ptr_q),
    .power_word  (power_word_i),
    .btemp_word  (board_temp_word_i),
    .dtemp_word  (die_temp_word_i),
    .vendor_id   (vendor_id_i),
    .device_id   (device_id_i),
    .subvendor_id(subvendor_id_i),
    .subsystem_id(subsystem_id_i),
    .name_word   (name_word_i),
    .sel_word    (sel_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      rx_sr     <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      host_nack <= 1'b1;
      snap_q    <= '0;
      tx_sr     <= '0;
      drive_low <= 1'b0;
    end else if (stop_det) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      drive_low <= 1'b0;
    end else if (start_det) begin
      state     <= ST_RX_ADDR;
      bit_cnt   <= '0;
      drive_low <= 1'b0;
    end else begin
      unique case (state)
        ST_RX_ADDR: begin
          if (scl_rise) begin
            rx_sr   <= {rx_sr[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == BIT_LAST) begin
            bit_cnt <= '0;
            if (rx_sr[7:1] == DEV_ADDR) begin
              state     <= ST_ADDR_ACK;
              drive_low <= 1'b1;
              rw_q      <= rx_sr[0];
              if (rx_sr[0]) snap_q <= sel_word;
            end else begin
              state <= ST_HOLD;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              state     <= ST_TX;
              tx_sr     <= snap_q[7:0];
              snap_q    <= {8'h00, snap_q[WORD_W-1:8]};
              byte_cnt  <= 3'd1;
              drive_low <= !snap_q[7];
            end else begin
              state     <= ST_RX_PTR;
              drive_low <= 1'b0;
            end
          end
        end
        ST_RX_PTR: begin
          if (scl_rise) begin
            rx_sr   <= {rx_sr[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == BIT_LAST) begin
            bit_cnt   <= '0;
            ptr_q     <= rx_sr;
            drive_low <= 1'b1;
            state     <= ST_PTR_ACK;
          end
        end
        ST_PTR_ACK: begin
          if (scl_fall) begin
            drive_low <= 1'b0;
            state     <= ST_HOLD;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt == BIT_LAST) begin
              bit_cnt   <= '0;
              drive_low <= 1'b0;
              state     <= ST_HOST_ACK;
            end else begin
              tx_sr     <= {tx_sr[6:0], 1'b0};
              drive_low <= !tx_sr[6];
            end
          end
        end
        ST_HOST_ACK: begin
          if (scl_rise) begin
            host_nack <= sda_s;
          end else if (scl_fall) begin
            if (!host_nack && byte_cnt < BYTE_LAST) begin
              state     <= ST_TX;
              tx_sr     <= snap_q[7:0];
              snap_q    <= {8'h00, snap_q[WORD_W-1:8]};
              byte_cnt  <= byte_cnt + 3'd1;
              drive_low <= !snap_q[7];
            end else begin
              state     <= ST_HOLD;
              drive_low <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = drive_low;

  // R1
  own_addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_ACK) |-> (rx_sr[7:1] == DEV_ADDR));

  // R1
  hold_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !drive_low);

  // R10
  drive_in_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((drive_low != $past(drive_low)) && !$past(start_det || stop_det)) |-> !$past(scl_s));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!drive_low && state == ST_IDLE));

  // R8
  byte_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= BYTE_LAST);
endmodule

// File: tb/smbrd_target_tb.sv
module smbrd_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_pull;
  wire  sda_line = host_sda & ~sda_pull;

  logic [31:0] pw  = 32'h4235_1EB8;
  logic [31:0] bt  = 32'h4208_0000;
  logic [31:0] dt  = 32'h4252_CCCD;
  logic [15:0] vid = 16'hCABD;
  logic [15:0] did = 16'h0100;
  logic [15:0] svid = 16'h1D17;
  logic [15:0] ssid = 16'h0010;
  logic [31:0] nm  = 32'h4D4C_5531;

  int compared = 0;
  int mismatched = 0;
  int glitch_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbrd_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull),
    .power_word_i(pw), .board_temp_word_i(bt), .die_temp_word_i(dt),
    .vendor_id_i(vid), .device_id_i(did), .subvendor_id_i(svid),
    .subsystem_id_i(ssid), .name_word_i(nm)
  );

  // R10 monitor: drive change while SCL high
  logic prev_pull = 1'b0;
  always @(posedge clk) begin
    if (rst_n && sda_pull != prev_pull && host_scl) glitch_cnt++;
    prev_pull <= sda_pull;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic quarter();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    host_scl = 1'b0; quarter();
    host_sda = 1'b1; quarter();
    host_scl = 1'b1; quarter();
    host_sda = 1'b0; quarter();
    host_scl = 1'b0; quarter();
  endtask

  task automatic bus_stop();
    host_scl = 1'b0; host_sda = 1'b0; quarter();
    host_scl = 1'b1; quarter();
    host_sda = 1'b1; quarter();
  endtask

  task automatic send_bit(input bit b);
    host_scl = 1'b0; quarter();
    host_sda = b;    quarter();
    host_scl = 1'b1; quarter(); quarter();
    host_scl = 1'b0;
  endtask

  task automatic get_bit(output bit b);
    host_scl = 1'b0; quarter();
    host_sda = 1'b1; quarter();
    host_scl = 1'b1; quarter();
    b = sda_line;    quarter();
    host_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(a);
    acked = !a;
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    send_bit(!give_ack);
  endtask

  function automatic logic [31:0] expect_word(input logic [7:0] p);
    case (p)
      8'h01: return pw;
      8'h02: return bt;
      8'h03: return dt;
      8'hA0: return {did, vid};
      8'hA1: return {ssid, svid};
      8'hF0: return nm;
      default: return 32'h0;
    endcase
  endfunction

  task automatic read_reg(input logic [7:0] p, output logic [31:0] w, output bit acks_ok);
    bit a0, a1, a2;
    logic [7:0] b;
    bus_start();
    send_byte(8'h8E, a0);
    send_byte(p, a1);
    bus_start();
    send_byte(8'h8F, a2);
    for (int k = 0; k < 4; k++) begin
      get_byte(k < 3, b);
      w[8*k +: 8] = b;
    end
    bus_stop();
    acks_ok = a0 && a1 && a2;
  endtask

  initial begin
    logic [31:0] w;
    logic [31:0] old;
    logic [7:0] b;
    bit ok, a;
    logic [7:0] ptrs [14] = '{8'h01, 8'h02, 8'h03, 8'hA0, 8'hA1, 8'hF0,
                              8'h00, 8'h04, 8'h80, 8'h9F, 8'hA2, 8'hEF, 8'hF1, 8'hFF};
    repeat (5) @(negedge clk);
    // R11
    check(sda_pull == 1'b0, "R11 reset release", {31'h0, sda_pull}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sda_pull == 1'b0, "R11 idle release", {31'h0, sda_pull}, 32'h0);

    // R1 R2: sweep every address byte
    for (int ab = 0; ab < 256; ab++) begin
      bus_start();
      send_byte(8'(ab), a);
      check(a == (ab[7:1] == 7'h47), "R1 address ack", {31'h0, a}, {31'h0, ab[7:1] == 7'h47});
      if (ab != 8'h8F) begin
        send_byte(8'(ab ^ 8'h5A), a);
        check(a == (ab == 8'h8E), "R2/R1 following byte ack", {31'h0, a}, {31'h0, ab == 8'h8E});
      end else begin
        for (int k = 0; k < 4; k++) get_byte(k < 3, b);
      end
      bus_stop();
    end

    // R3 R4 R5 R6: mapped and unmapped pointers
    foreach (ptrs[i]) begin
      read_reg(ptrs[i], w, ok);
      check(ok, "R2 pointer/address acks", {31'h0, ok}, 32'h1);
      check(w == expect_word(ptrs[i]),
            (ptrs[i] inside {8'h01, 8'h02, 8'h03}) ? "R4/R3 sensor word" :
            (ptrs[i] inside {8'hA0, 8'hA1, 8'hF0}) ? "R5/R3 id word" : "R6 unmapped zero",
            w, expect_word(ptrs[i]));
    end

    // R7: inputs change mid read
    old = pw;
    bus_start(); send_byte(8'h8E, a); send_byte(8'h01, a);
    bus_start(); send_byte(8'h8F, a);
    get_byte(1'b1, b); w[7:0] = b;
    pw = 32'hDEAD_BEEF;
    for (int k = 1; k < 4; k++) begin
      get_byte(k < 3, b);
      w[8*k +: 8] = b;
    end
    bus_stop();
    check(w == old, "R7 snapshot", w, old);
    read_reg(8'h01, w, ok);
    check(w == 32'hDEAD_BEEF, "R7 new value next read", w, 32'hDEAD_BEEF);

    // R8: host NACK on byte 2, then extra clocks read 0xFF
    bus_start(); send_byte(8'h8E, a); send_byte(8'hA0, a);
    bus_start(); send_byte(8'h8F, a);
    get_byte(1'b1, b); w[7:0] = b;
    get_byte(1'b0, b); w[15:8] = b;
    check(w[15:0] == vid, "R8 bytes before NACK", {16'h0, w[15:0]}, {16'h0, vid});
    get_byte(1'b0, b);
    check(b == 8'hFF, "R8 released after NACK", {24'h0, b}, 32'hFF);
    bus_stop();

    // R8: host ACKs fourth byte, target still stops
    bus_start(); send_byte(8'h8E, a); send_byte(8'hF0, a);
    bus_start(); send_byte(8'h8F, a);
    for (int k = 0; k < 4; k++) get_byte(1'b1, b);
    get_byte(1'b0, b);
    check(b == 8'hFF, "R8 released after fourth byte", {24'h0, b}, 32'hFF);
    bus_stop();

    // R9: STOP after pointer, then full read
    bus_start(); send_byte(8'h8E, a); send_byte(8'hA1, a);
    bus_stop();
    repeat (8) @(negedge clk);
    check(sda_pull == 1'b0, "R9 released after STOP", {31'h0, sda_pull}, 32'h0);
    read_reg(8'h03, w, ok);
    check(ok && w == dt, "R9 read after STOP", w, dt);

    // R9: START in the middle of an address byte
    bus_start();
    for (int i = 7; i >= 4; i--) send_bit(1'b1 ^ i[0]);
    read_reg(8'hA1, w, ok);
    check(ok && w == {ssid, svid}, "R9 read after mid-byte START", w, {ssid, svid});

    // R10
    check(glitch_cnt == 0, "R10 drive changes only with SCL low", glitch_cnt, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule